// File: doc/BRIEF.md
# Normalizing Barrel Shifter with Leading-Digit Encoder

This block moves a 32-bit word by a coded distance and presents one 16-bit half of the result. It has two ways of shifting. In rotate mode the word turns circularly to the left. In fill mode the word moves in a straight line: a left move brings zeros in at the bottom, and a right move copies the sign input in at the top. In fill mode the direction pin works as the top bit of a six-bit two's-complement distance. A zero on that pin gives a left move of 0 to 31 places. A one gives a right move of 1 to 32 places.

Beside the shifter sits a leading-digit encoder. It reports how many places to the left the word must move so that its first significant bit reaches the top. Before the search, every data bit is XORed with the sign input, so a two's-complement negative value is normalized on its first zero. When normalize is asserted, the encoder count replaces the external shift code, and a word can be normalized in a single pass. For this use, select fill mode with the direction pin low.

All results are registered once on the clock. A low output enable forces the data output to zero and drops the valid flag.

Top module: `norm_shifter32`

## Requirements
- R1: While reset is low, and at the first clock edge after it, `dout`, `dout_vld` and `lead_cnt` are all zero.
- R2: With `fill_mode`=0, bit j of the 32-bit shifted word equals `din[(j - code) mod 32]`, so the word rotates left by `code`. The value of `dir_right` has no effect on this result.
- R3: With `fill_mode`=1 and `dir_right`=0, the word moves left by `code` places (0 to 31), and zeros fill the vacated low bits.
- R4: With `fill_mode`=1 and `dir_right`=1, the word moves right by 32 minus `code` places, and `sign_in` fills the vacated high bits. A code of 11111 therefore moves one place, and a code of 00000 makes every bit equal to `sign_in`.
- R5: When `hi_half`=1, `dout` carries bits 31:16 of the shifted word. When `hi_half`=0, it carries bits 15:0.
- R6: The encoder searches `din ^ {32{sign_in}}`. The shifter always works on the unmodified `din`.
- R7: `lead_cnt` equals 31 minus the index of the highest set bit of the encoder input, which gives 0 when bit 31 is set. It is 31 when the encoder input is all zero.
- R8: When `norm_en`=1, the encoder count is used as `code` in place of `shamt_in`. Otherwise `code` is `shamt_in`.
- R9: When `out_en`=0, `dout` is zero and `dout_vld` is 0. When `out_en`=1, `dout_vld` is 1.
- R10: `dout`, `dout_vld` and `lead_cnt` reflect the inputs present at the previous rising clock edge, and they do not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Data word |
| sign_in | input | 1 | Fill value for right moves; XOR mask for the encoder |
| shamt_in | input | 5 | External shift code |
| dir_right | input | 1 | Direction in fill mode; sign of the six-bit distance |
| fill_mode | input | 1 | 1 = linear fill, 0 = rotate |
| norm_en | input | 1 | Use the encoder count as the shift code |
| hi_half | input | 1 | 1 = upper half to output, 0 = lower half |
| out_en | input | 1 | Output enable |
| dout | output | 16 | Selected half of the shifted word |
| dout_vld | output | 1 | Output valid |
| lead_cnt | output | 5 | Leading-digit encoder count |

## Verification
Two functions can act in the same cycle: the encoder search and the shift that uses its count. This happens when normalize is asserted. The bench provokes it with positive words, with negative words where the sign XOR makes the search look for a zero, and with all-zero and all-one words where the count saturates at 31. The bench also draws random mode mixes in which normalize meets rotate mode or right fill. In every case the bench computes the count by a top-down bit search and the result by taking a window from a 96-bit sign-extended, zero-padded copy of the word. It compares both against the design on every cycle.

// File: rtl/norm_shifter32.sv
module norm_shifter32 #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         din,
  input  logic                 sign_in,
  input  logic [$clog2(W)-1:0] shamt_in,
  input  logic                 dir_right,
  input  logic                 fill_mode,
  input  logic                 norm_en,
  input  logic                 hi_half,
  input  logic                 out_en,
  output logic [W/2-1:0]       dout,
  output logic                 dout_vld,
  output logic [$clog2(W)-1:0] lead_cnt
);
  localparam int SW = $clog2(W);
  localparam int HW = W / 2;
  localparam int XW = SW + 2;

  logic [W-1:0]   enc_in;
  logic [SW-1:0]  lead;
  logic [SW-1:0]  code;
  logic [2*W-1:0] dbl;
  logic [3*W-1:0] ext;
  logic [XW-1:0]  low_idx;
  logic [W-1:0]   rot, fil, shifted;

  assign enc_in = din ^ {W{sign_in}};

  always_comb begin
    lead = SW'(W-1);
    for (int i = 0; i < W; i++)
      if (enc_in[i]) lead = SW'(W-1-i);
  end

  assign code    = norm_en ? lead : shamt_in;
  assign dbl     = {din, din} << code;
  assign rot     = dbl[2*W-1:W];
  assign ext     = {{W{sign_in}}, din, {W{1'b0}}};
  assign low_idx = (dir_right ? XW'(2*W) : XW'(W)) - XW'(code);
  assign fil     = W'(ext >> low_idx);
  assign shifted = fill_mode ? fil : rot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
      lead_cnt <= '0;
    end else begin
      dout     <= out_en ? (hi_half ? shifted[W-1:HW] : shifted[HW-1:0]) : '0;
      dout_vld <= out_en;
      lead_cnt <= lead;
    end
  end

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (dout == '0) && !dout_vld);

  // R7
  lead_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((din ^ {W{sign_in}}) != '0) |=>
      (($past(din ^ {W{sign_in}}) >> (SW'(W-1) - lead_cnt)) == W'(1)));

  // R7
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din == {W{sign_in}}) |=> lead_cnt == SW'(W-1));

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !norm_en && shamt_in == '0 && !fill_mode) |=>
      dout == $past(hi_half ? din[W-1:HW] : din[HW-1:0]));

  // R4
  full_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !norm_en && shamt_in == '0 && fill_mode && dir_right) |=>
      dout == {HW{$past(sign_in)}});
endmodule

// File: tb/norm_shifter32_tb.sv
module norm_shifter32_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] din = 0;
  logic        sign_in = 0, dir_right = 0, fill_mode = 0, norm_en = 0, hi_half = 0, out_en = 0;
  logic [4:0]  shamt_in = 0;
  logic [15:0] dout;
  logic        dout_vld;
  logic [4:0]  lead_cnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] e_dout;
  logic        e_vld;
  logic [4:0]  e_lead;

  always #10 clk = ~clk;

  norm_shifter32 u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sign_in(sign_in), .shamt_in(shamt_in),
    .dir_right(dir_right), .fill_mode(fill_mode), .norm_en(norm_en), .hi_half(hi_half),
    .out_en(out_en), .dout(dout), .dout_vld(dout_vld), .lead_cnt(lead_cnt)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model();
    logic [31:0] w, r;
    logic [95:0] ext;
    int lz, code, s;
    w  = din ^ {32{sign_in}};
    lz = 31;
    for (int i = 31; i >= 0; i--) if (w[i]) begin lz = 31 - i; break; end
    code = norm_en ? lz : int'(shamt_in);
    if (!fill_mode) begin
      for (int j = 0; j < 32; j++) r[j] = din[(j - code + 32) % 32];
    end else begin
      s   = dir_right ? code - 32 : code;
      ext = {{32{sign_in}}, din, 32'h0};
      for (int j = 0; j < 32; j++) r[j] = ext[32 - s + j];
    end
    e_lead = 5'(lz);
    e_vld  = out_en;
    e_dout = !out_en ? 16'h0 : (hi_half ? r[31:16] : r[15:0]);
  endtask

  task automatic apply(input logic [31:0] d, input logic sg, input logic [4:0] sh,
                       input logic dr, input logic fm, input logic nm, input logic hh,
                       input logic oe, input string tag);
    @(negedge clk);
    din = d; sign_in = sg; shamt_in = sh; dir_right = dr; fill_mode = fm;
    norm_en = nm; hi_half = hh; out_en = oe;
    model();
    @(posedge clk); #5;
    check(32'(dout), 32'(e_dout), {tag, " dout"});
    check(32'(dout_vld), 32'(e_vld), "R9 dout_vld");
    check(32'(lead_cnt), 32'(e_lead), sg ? "R6/R7 lead_cnt" : "R7 lead_cnt");
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(32'(dout), 0, "R1 reset dout");
    check(32'(dout_vld), 0, "R1 reset vld");
    check(32'(lead_cnt), 0, "R1 reset lead");
    @(negedge clk); rst_n = 1;

    // R2 rotate, direction ignored, both halves (R5)
    apply(32'h8000_0001, 0, 5'd1, 0, 0, 0, 1, 1, "R2 rot hi");
    apply(32'h8000_0001, 0, 5'd1, 1, 0, 0, 0, 1, "R2 rot lo dir1");
    apply(32'h1234_5678, 1, 5'd16, 1, 0, 0, 1, 1, "R5 rot16 hi");
    apply(32'h1234_5678, 1, 5'd16, 0, 0, 0, 0, 1, "R5 rot16 lo");
    // R3 fill left
    apply(32'hF000_000F, 1, 5'd4, 0, 1, 0, 0, 1, "R3 left4 lo");
    apply(32'hF000_000F, 1, 5'd31, 0, 1, 0, 1, 1, "R3 left31 hi");
    // R4 fill right
    apply(32'h8000_0000, 1, 5'd31, 1, 1, 0, 1, 1, "R4 right1 hi");
    apply(32'h0000_0003, 0, 5'd31, 1, 1, 0, 0, 1, "R4 right1 lo");
    apply(32'h1234_5678, 1, 5'd0, 1, 1, 0, 0, 1, "R4 right32 sign");
    apply(32'hFFFF_FFFF, 0, 5'd0, 1, 1, 0, 1, 1, "R4 right32 zero");
    // R6 encoder XOR, raw shift data
    apply(32'hFFFF_0000, 1, 5'd0, 0, 0, 0, 0, 1, "R6 raw lo");
    apply(32'hFFFF_0000, 1, 5'd0, 0, 0, 0, 1, 1, "R6 raw hi");
    // R7 encoder edges
    apply(32'h0000_0000, 0, 5'd3, 0, 1, 0, 0, 1, "R7 zero word");
    apply(32'hFFFF_FFFF, 1, 5'd3, 0, 1, 0, 0, 1, "R7 ones neg");
    apply(32'h0000_0001, 0, 5'd3, 0, 1, 0, 0, 1, "R7 bit0");
    apply(32'h8000_0000, 0, 5'd3, 0, 1, 0, 0, 1, "R7 bit31");
    // R8 normalize
    apply(32'h0001_2345, 0, 5'd7, 0, 1, 1, 1, 1, "R8 norm hi");
    apply(32'h0001_2345, 0, 5'd7, 0, 1, 1, 0, 1, "R8 norm lo");
    apply(32'hFFFE_1234, 1, 5'd0, 0, 1, 1, 1, 1, "R8 norm neg");
    apply(32'h0000_0000, 0, 5'd0, 0, 1, 1, 1, 1, "R8 norm zero");
    // R9 output enable
    apply(32'hDEAD_BEEF, 0, 5'd5, 0, 0, 0, 1, 0, "R9 oe off");

    // R10 output holds until the next edge
    @(negedge clk);
    din = 32'hAAAA_5555; shamt_in = 5'd0; fill_mode = 0; norm_en = 0; hi_half = 0; out_en = 1;
    #2;
    check(32'(dout), 0, "R10 no change before edge");
    check(32'(dout_vld), 0, "R10 vld before edge");
    @(posedge clk); #5;
    check(32'(dout), 32'h5555, "R10 after edge");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] d;
      logic fm, nm, dr, oe;
      string tg;
      d = $urandom;
      if (k % 3 == 0) d = d >> ($urandom % 32);
      fm = $urandom % 2; nm = ($urandom % 4) == 0; dr = $urandom % 2; oe = ($urandom % 8) != 0;
      tg = !oe ? "R9" : nm ? "R8" : !fm ? "R2" : dr ? "R4" : "R3";
      apply(d, 1'($urandom), 5'($urandom), dr, fm, nm, 1'($urandom), oe, {tg, " random"});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule